// File: doc/BRIEF.md
# Three-level page table walker

This block translates a 64-bit virtual address into a physical address. The caller supplies the kind of access it wants (read, write, execute, or none for a probe) and a privilege mode. Two checks come before any memory traffic. An address that is not properly sign-extended fails at once. A negative address inside the kernel superpage window is mapped directly, with no walk.

Every other address is resolved by reading up to three page table entries, one at a time. The reads go through a simple request/response memory port, and the walk starts at a table base input. Each entry is checked as it arrives. The walk stops at the first fault. The result comes back as a single-cycle done pulse that carries the physical address, the granted permissions and a prioritised fault code.

The block sits between a TLB miss path and the memory system. It holds no translations of its own.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, `done` is 0 and `mem_req_valid` is 0.
- R2: A request is non-canonical when bits 63 down to VA_BITS are not all equal. Such a request completes with fault ACV, issues no memory read, and raises `done` in the cycle after acceptance.
- R3: The superpage window is a canonical address with bit 63 set and bits 42:41 equal to 2'b10. It issues no memory read. In mode 0 (kernel) it returns fault NONE, permission 3'b111 and a physical address made of va[39:0] with va[40] placed at bit 43 and all other bits zero. Any non-zero mode returns ACV.
- R4: A walk reads the level 1, level 2 and level 3 entries strictly in that order. Each entry address is the current table base plus index*8. The 10-bit index comes from va starting at bit PAGE_BITS+20, then PAGE_BITS+10, then PAGE_BITS. The first base is `tbl_base`. Each later base is the previous entry's bits 63:32 shifted left by PAGE_BITS.
- R5: Entry bit 0 is the valid bit. If it is clear at any level, the walk ends with fault TNV and no further reads are made.
- R6: A level 1 or level 2 entry whose kernel-read bit (bit 8) is clear ends the walk with fault ACV.
- R7: At level 3, read is enabled by bit 8+mode and write by bit 12+mode. Read enable grants read and execute. Write enable grants write. Permission bits are bit 0 read, bit 1 write, bit 2 execute.
- R8: At level 3, if the requested access (same bit encoding as permission) is non-zero and shares no bit with the granted set, the fault is ACV. A request of 0 never faults at level 3.
- R9: After the R8 check, entry bits 1, 2 and 3 remove read, write and execute from the granted set. If the request then shares no bit with what remains, the fault is FOE when execute was requested, otherwise FOW when write was requested, otherwise FOR.
- R10: A completed walk raises `done` for one cycle. Fault codes are NONE=0, ACV=1, TNV=2, FOR=3, FOW=4, FOE=5. On NONE the address is the final frame base ORed with va[PAGE_BITS-1:0], and the permission is what remains after R9. On any fault both are zero.
- R11: Only one memory read is outstanding at a time. `mem_req_addr` holds steady while a request waits for `mem_req_ready`. `req_ready` is low during a walk, and requests offered while it is low are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 64 | Virtual address to translate |
| req_access | input | 3 | Requested access: bit 0 read, bit 1 write, bit 2 execute |
| req_mode | input | MODE_W | Privilege mode index, 0 is kernel |
| tbl_base | input | 64 | Physical base of the level 1 table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Physical address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry contents |
| done | output | 1 | One-cycle completion pulse |
| done_pa | output | 64 | Translated physical address |
| done_perm | output | 3 | Granted permissions |
| done_fault | output | 3 | Fault code |

## Verification
The bench uses the default parameters: 43 implemented address bits, 8 KB pages, 10-bit indices and three levels. With these values the level indices fall at bits 33, 23 and 13. The page tables can therefore sit at small physical addresses such as 0x2000, 0x4000 and 0x6000, while the upper canonical and superpage bits can still be set independently. Level 3 entries are built with every mix of the enable bits and the fault-on bits, and they are read in kernel, user and higher modes. This covers each fault code, the priority among them, the probe case and the superpage relocation of bit 40. The memory model stalls its ready signal on a fixed pattern, and one test forces a long stall, so that request holding and ignored offers can be seen at the ports.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_ACV  = 3'd1,
        FLT_TNV  = 3'd2,
        FLT_FOR  = 3'd3,
        FLT_FOW  = 3'd4,
        FLT_FOE  = 3'd5
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } walk_st_e;

    // Entry bit positions.
    localparam int PTE_VALID = 0;
    localparam int PTE_FOR   = 1;
    localparam int PTE_FOE   = 3;
    localparam int PTE_KRD   = 8;
    localparam int PTE_KWR   = 12;

    localparam logic [2:0] PERM_ALL = 3'b111;
endpackage

// File: rtl/ptw_va_class.sv
module ptw_va_class #(
    parameter int VA_BITS = 43
) (
    input  logic [63:0] va,
    output logic        canonical,
    output logic        superpage,
    output logic [63:0] sp_pa
);
    localparam int HI_W = 64 - VA_BITS;

    // Upper bits must all copy the sign bit.
    assign canonical = (va[63:VA_BITS] == {HI_W{va[63]}});
    // Negative address with window select 2'b10.
    assign superpage = va[63] && (va[42:41] == 2'b10);
    // Low 40 bits pass through, bit 40 relocates to bit 43.
    assign sp_pa     = {20'd0, va[40], 3'd0, va[39:0]};
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
    import ptw_pkg::*;
#(
    parameter int PAGE_BITS = 13,
    parameter int MODE_W    = 2
) (
    input  logic [63:0]          pte,
    input  logic                 last_lvl,
    input  logic [2:0]           need,
    input  logic [MODE_W-1:0]    mode,
    input  logic [PAGE_BITS-1:0] page_off,
    output fault_e               fault,
    output logic [63:0]          next_base,
    output logic [63:0]          pa,
    output logic [2:0]           perm
);
    logic [5:0] rd_pos, wr_pos;
    logic       rd_en, wr_en;
    logic [2:0] grant, kept;

    assign rd_pos    = 6'(PTE_KRD) + 6'(mode);
    assign wr_pos    = 6'(PTE_KWR) + 6'(mode);
    assign rd_en     = pte[rd_pos];
    assign wr_en     = pte[wr_pos];
    assign next_base = {32'd0, pte[63:32]} << PAGE_BITS;
    assign pa        = next_base | {{(64-PAGE_BITS){1'b0}}, page_off};

    always_comb begin
        grant = {rd_en, wr_en, rd_en};            // {exec, write, read}
        kept  = grant & ~pte[PTE_FOE:PTE_FOR];    // fault-on bits strip rights
        perm  = kept;
        fault = FLT_NONE;
        if (!pte[PTE_VALID]) begin
            fault = FLT_TNV;
        end else if (!last_lvl) begin
            if (!pte[PTE_KRD]) fault = FLT_ACV;
        end else if ((need != 3'd0) && ((grant & need) == 3'd0)) begin
            fault = FLT_ACV;
        end else if ((need != 3'd0) && ((kept & need) == 3'd0)) begin
            fault = need[2] ? FLT_FOE : (need[1] ? FLT_FOW : FLT_FOR);
        end
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int VA_BITS   = 43,
    parameter int PAGE_BITS = 13,
    parameter int IDX_BITS  = 10,
    parameter int LEVELS    = 3,
    parameter int MODE_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [63:0]       req_va,
    input  logic [2:0]        req_access,
    input  logic [MODE_W-1:0] req_mode,
    input  logic [63:0]       tbl_base,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [63:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data,
    output logic              done,
    output logic [63:0]       done_pa,
    output logic [2:0]        done_perm,
    output logic [2:0]        done_fault
);
    localparam int          LVL_W    = $clog2(LEVELS);
    localparam logic [LVL_W-1:0] LAST = LVL_W'(LEVELS - 1);
    localparam logic [63:0] IDX_MASK = (64'd1 << IDX_BITS) - 64'd1;

    typedef struct packed {
        walk_st_e          st;
        logic [LVL_W-1:0]  lvl;
        logic [63:0]       va;
        logic [2:0]        need;
        logic [MODE_W-1:0] mode;
        logic [63:0]       addr;
        logic              done;
        logic [63:0]       pa;
        logic [2:0]        perm;
        fault_e            flt;
    } walk_t;

    walk_t w_d, w_q;

    // Byte offset of the entry for level lvl inside its table.
    function automatic logic [63:0] entry_off(input logic [63:0] va,
                                              input logic [LVL_W-1:0] lvl);
        logic [63:0] sh;
        sh = va >> (PAGE_BITS + IDX_BITS * (LEVELS - 1 - int'(lvl)));
        return (sh & IDX_MASK) << 3;
    endfunction

    logic        is_canon, is_super;
    logic [63:0] super_pa;

    ptw_va_class #(.VA_BITS(VA_BITS)) u_class (
        .va        (req_va),
        .canonical (is_canon),
        .superpage (is_super),
        .sp_pa     (super_pa)
    );

    fault_e      ev_fault;
    logic [63:0] ev_base, ev_pa;
    logic [2:0]  ev_perm;

    ptw_pte_eval #(.PAGE_BITS(PAGE_BITS), .MODE_W(MODE_W)) u_eval (
        .pte       (mem_rsp_data),
        .last_lvl  (w_q.lvl == LAST),
        .need      (w_q.need),
        .mode      (w_q.mode),
        .page_off  (w_q.va[PAGE_BITS-1:0]),
        .fault     (ev_fault),
        .next_base (ev_base),
        .pa        (ev_pa),
        .perm      (ev_perm)
    );

    always_comb begin
        w_d      = w_q;
        w_d.done = 1'b0;
        unique case (w_q.st)
            ST_IDLE: if (req_valid) begin
                w_d.va   = req_va;
                w_d.need = req_access;
                w_d.mode = req_mode;
                w_d.lvl  = '0;
                if (!is_canon || (is_super && req_mode != '0)) begin
                    w_d.done = 1'b1;
                    w_d.flt  = FLT_ACV;
                    w_d.pa   = '0;
                    w_d.perm = '0;
                end else if (is_super) begin
                    w_d.done = 1'b1;
                    w_d.flt  = FLT_NONE;
                    w_d.pa   = super_pa;
                    w_d.perm = PERM_ALL;
                end else begin
                    w_d.st   = ST_REQ;
                    w_d.addr = tbl_base + entry_off(req_va, '0);
                end
            end
            ST_REQ: if (mem_req_ready) w_d.st = ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) begin
                if (ev_fault != FLT_NONE) begin
                    w_d.st   = ST_IDLE;
                    w_d.done = 1'b1;
                    w_d.flt  = ev_fault;
                    w_d.pa   = '0;
                    w_d.perm = '0;
                end else if (w_q.lvl == LAST) begin
                    w_d.st   = ST_IDLE;
                    w_d.done = 1'b1;
                    w_d.flt  = FLT_NONE;
                    w_d.pa   = ev_pa;
                    w_d.perm = ev_perm;
                end else begin
                    w_d.st   = ST_REQ;
                    w_d.lvl  = w_q.lvl + 1'b1;
                    w_d.addr = ev_base + entry_off(w_q.va, w_q.lvl + 1'b1);
                end
            end
            default: w_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign req_ready     = (w_q.st == ST_IDLE);
    assign mem_req_valid = (w_q.st == ST_REQ);
    assign mem_req_addr  = w_q.addr;
    assign done          = w_q.done;
    assign done_pa       = w_q.pa;
    assign done_perm     = w_q.perm;
    assign done_fault    = w_q.flt;

    a_r11_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)))
        else $error("a_r11_hold_addr");

    a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready)
        else $error("a_r11_busy");

    a_r2_noncanon: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !is_canon) |=> (done && done_fault == 3'(FLT_ACV)))
        else $error("a_r2_noncanon");

    a_r10_clean_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_fault != 3'd0) |-> (done_pa == 64'd0 && done_perm == 3'd0))
        else $error("a_r10_clean_fault");

    a_r10_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_fault <= 3'd5))
        else $error("a_r10_code_range");
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_va = '0;
    logic [2:0]  req_access = '0;
    logic [1:0]  req_mode = '0;
    logic [63:0] tbl_base = 64'h2000;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        done;
    logic [63:0] done_pa;
    logic [2:0]  done_perm;
    logic [2:0]  done_fault;

    always #4 clk = ~clk;   // 125 MHz

    pt_walker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_access(req_access), .req_mode(req_mode),
        .tbl_base(tbl_base), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .done_pa(done_pa), .done_perm(done_perm),
        .done_fault(done_fault)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory image and model
    logic [63:0] mem_img [logic [63:0]];
    logic        stall_force = 1'b0;
    logic        rsp_pend = 1'b0;
    logic [63:0] pend_addr = '0;
    int          rd_count = 0;
    int          cyc = 0;

    function automatic logic [63:0] lookup(input logic [63:0] a);
        if (mem_img.exists(a)) return mem_img[a];
        return 64'd0;
    endfunction

    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (rsp_pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = lookup(pend_addr);
                rsp_pend      = 1'b0;
            end else begin
                mem_rsp_valid = 1'b0;
            end
            mem_req_ready = !stall_force && ((cyc % 3) != 1);
            if (rst_n && mem_req_valid && mem_req_ready) begin
                rsp_pend  = 1'b1;
                pend_addr = mem_req_addr;
                rd_count++;
            end
        end
    end

    task automatic walk(input logic [63:0] va, input logic [2:0] acc, input logic [1:0] mode,
                        output logic [2:0] flt, output logic [63:0] pa,
                        output logic [2:0] perm, output int reads);
        int r0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        r0 = rd_count;
        req_valid = 1'b1; req_va = va; req_access = acc; req_mode = mode;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        flt = done_fault; pa = done_pa; perm = done_perm;
        reads = rd_count - r0;
    endtask

    typedef struct packed {
        logic [63:0] va;
        logic [2:0]  acc;
        logic [1:0]  mode;
        logic [2:0]  flt;
        logic [63:0] pa;
        logic [2:0]  perm;
        logic [1:0]  reads;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        // R4 R7 full walk, kernel read
        '{64'h123, 3'd1, 2'd0, 3'd0, 64'h200123, 3'd7, 2'd3, 4'd4},
        // R7 user write through user enable bits
        '{64'hABC, 3'd2, 2'd1, 3'd0, 64'h200ABC, 3'd7, 2'd3, 4'd7},
        // R8 write with read-only grant
        '{64'h2010, 3'd2, 2'd0, 3'd1, 64'h0, 3'd0, 2'd3, 4'd8},
        // R7 read enable grants execute
        '{64'h2010, 3'd4, 2'd0, 3'd0, 64'h202010, 3'd5, 2'd3, 4'd7},
        // R7 user has no read enable here
        '{64'h2010, 3'd1, 2'd1, 3'd1, 64'h0, 3'd0, 2'd3, 4'd7},
        // R8 probe never faults at level 3
        '{64'h2010, 3'd0, 2'd1, 3'd0, 64'h202010, 3'd0, 2'd3, 4'd8},
        // R9 fault-on-write
        '{64'h4008, 3'd2, 2'd0, 3'd4, 64'h0, 3'd0, 2'd3, 4'd9},
        // R9 read unaffected by FOW
        '{64'h4008, 3'd1, 2'd0, 3'd0, 64'h204008, 3'd5, 2'd3, 4'd9},
        // R9 fault-on-execute
        '{64'h6004, 3'd4, 2'd0, 3'd5, 64'h0, 3'd0, 2'd3, 4'd9},
        // R9 fault-on-read
        '{64'h6004, 3'd1, 2'd0, 3'd3, 64'h0, 3'd0, 2'd3, 4'd9},
        // R9 priority: execute over read
        '{64'h6004, 3'd5, 2'd0, 3'd5, 64'h0, 3'd0, 2'd3, 4'd9},
        // R10 write survives, only W kept
        '{64'h6004, 3'd2, 2'd0, 3'd0, 64'h206004, 3'd2, 2'd3, 4'd10},
        // R9 read|write: one right left, no fault
        '{64'h6004, 3'd3, 2'd0, 3'd0, 64'h206004, 3'd2, 2'd3, 4'd9},
        // R5 invalid at level 3
        '{64'h8000, 3'd1, 2'd0, 3'd2, 64'h0, 3'd0, 2'd3, 4'd5},
        // R5 invalid at level 2
        '{64'h80_0000, 3'd1, 2'd0, 3'd2, 64'h0, 3'd0, 2'd2, 4'd5},
        // R6 level 2 without kernel read
        '{64'h100_0000, 3'd1, 2'd0, 3'd1, 64'h0, 3'd0, 2'd2, 4'd6},
        // R5 invalid at level 1
        '{64'h2_0000_0000, 3'd1, 2'd0, 3'd2, 64'h0, 3'd0, 2'd1, 4'd5},
        // R6 level 1 without kernel read
        '{64'h4_0000_0000, 3'd1, 2'd0, 3'd1, 64'h0, 3'd0, 2'd1, 4'd6},
        // R3 superpage with bit 40 moved to 43
        '{64'hFFFF_FD00_0000_1234, 3'd2, 2'd0, 3'd0, 64'h0000_0800_0000_1234, 3'd7, 2'd0, 4'd3},
        // R3 superpage from user mode
        '{64'hFFFF_FD00_0000_1234, 3'd1, 2'd1, 3'd1, 64'h0, 3'd0, 2'd0, 4'd3},
        // R2 bit 43 set, sign clear
        '{64'h0000_0800_0000_0000, 3'd1, 2'd0, 3'd1, 64'h0, 3'd0, 2'd0, 4'd2},
        // R2 negative with a hole in upper bits
        '{64'hFFFF_0000_0000_0000, 3'd1, 2'd0, 3'd1, 64'h0, 3'd0, 2'd0, 4'd2},
        // R4 negative non-superpage walks, index 1023 reads empty slot
        '{64'hFFFF_FFFF_FFFF_E000, 3'd1, 2'd0, 3'd2, 64'h0, 3'd0, 2'd1, 4'd4},
        // R3 superpage with bit 40 clear
        '{64'hFFFF_FC00_0000_0040, 3'd4, 2'd0, 3'd0, 64'h40, 3'd7, 2'd0, 4'd3},
        // R7 mode 2 selects bits 10 and 14, both clear
        '{64'h123, 3'd1, 2'd2, 3'd1, 64'h0, 3'd0, 2'd3, 4'd7}
    };

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [2:0]  flt;
        logic [63:0] pa;
        logic [2:0]  perm;
        int          reads;
        int          idle_done;

        mem_img[64'h2000] = 64'h0000_0002_0000_0101;
        mem_img[64'h2010] = 64'h0000_0005_0000_0001;
        mem_img[64'h4000] = 64'h0000_0003_0000_0101;
        mem_img[64'h4010] = 64'h0000_0000_0000_0001;
        mem_img[64'h6000] = 64'h0000_0100_0000_3301;
        mem_img[64'h6008] = 64'h0000_0101_0000_0101;
        mem_img[64'h6010] = 64'h0000_0102_0000_1105;
        mem_img[64'h6018] = 64'h0000_0103_0000_110B;

        repeat (3) @(negedge clk);
        // R1 reset state while held
        check("R1 ready in reset", 64'(req_ready), 64'd1);
        check("R1 done in reset", 64'(done), 64'd0);
        check("R1 mem_req_valid in reset", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", 64'(req_ready), 64'd1);
        check("R1 mem idle after reset", 64'(mem_req_valid), 64'd0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            walk(VECS[i].va, VECS[i].acc, VECS[i].mode, flt, pa, perm, reads);
            check({tag, " fault"}, 64'(flt), 64'(VECS[i].flt));
            check({tag, " pa"}, pa, VECS[i].pa);
            check({tag, " perm"}, 64'(perm), 64'(VECS[i].perm));
            check({tag, " reads"}, 64'(reads), 64'(VECS[i].reads));
        end

        // R11 stalled request holds its address; offers while busy are ignored
        stall_force = 1'b1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_va = 64'h123; req_access = 3'd1; req_mode = 2'd0;
        @(negedge clk);
        req_access = 3'd2; req_va = 64'h2010;   // stray offer, must be ignored
        for (int k = 0; k < 3; k++) begin
            check("R11 valid held", 64'(mem_req_valid), 64'd1);
            check("R11 addr held", mem_req_addr, 64'h2000);
            check("R11 busy", 64'(req_ready), 64'd0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        stall_force = 1'b0;
        while (!done) @(negedge clk);
        check("R11 original result fault", 64'(done_fault), 64'd0);
        check("R11 original result pa", done_pa, 64'h200123);
        idle_done = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (done) idle_done++;
        end
        check("R11 no second result", 64'(idle_done), 64'd0);
        // R10 pulse lasts one cycle
        check("R10 done dropped", 64'(done), 64'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule